// File: doc/BRIEF.md
# Oscillator Interrupt Flag Unit

This block collects interrupt events for a low-frequency oscillator controller. Three live status inputs come in: external crystal ready, internal oscillator ready and crystal clock failure. Each input has a sticky flag, and the flag latches when its input goes from low to high. A high level on its own does not set the flag. The interrupt request output is the registered OR of every flag whose enable bit is 1.

Software reaches the block over a simple single-cycle register bus. Read data is combinational and writes take effect at the clock edge. Writing ones to the flag register clears those flags. Writing ones to a separate set alias sets flags, so an interrupt handler can be exercised without real oscillator events, and reading that alias returns the flag state. The enable bits have their own set and clear aliases. A write-lock input blocks writes to the set alias and to both enable aliases. Flag clears are never blocked, because handlers must always be able to acknowledge an interrupt.

Top module: `osc_irq_ctrl`

## Requirements
- R1: After reset the flags, the enables and `irq` are all 0, and reading any register except live status returns 0.
- R2: A flag bit is set at the clock edge where its status input is 1 and was 0 at the previous edge. A status input that stays high does not set its flag again after that flag has been cleared. Bit 0 is crystal ready, bit 1 is oscillator ready and bit 2 is clock failure.
- R3: Writing to offset 0x08 clears every flag whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged.
- R4: Writing to offset 0x10 sets every flag whose write-data bit is 1, and 0 bits have no effect. Reading offsets 0x10 and 0x08 both returns the flag bits in data bits 2..0.
- R5: While `wr_lock` is 1, writes to offsets 0x10, 0x04 and 0x00 are ignored. A flag clear through offset 0x08 still takes effect.
- R6: Writing ones to offset 0x04 sets enable bits and writing ones to offset 0x00 clears them. Reading either offset returns the enable bits.
- R7: `irq` equals the OR of (flag AND enable), delayed by exactly one clock edge.
- R8: If a rising status edge and a clear write hit the same flag at the same edge, the flag ends up set.
- R9: A status input that is already high while reset is asserted sets its flag at the first clock edge after reset is released.
- R10: Data bits 31..3 always read as 0, and writing them has no effect. Offset 0x0C returns the live status inputs. Any unmapped offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, acts at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wr_lock | input | 1 | Write protection for the set and enable aliases |
| status_in | input | 3 | Live status: crystal ready, oscillator ready, clock failure |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is the collision of a hardware rising edge with a software clear on the same flag in the same cycle. The bus has only one port, and the edge must land exactly on the edge where the clear write is sampled. The bench reaches it in a dedicated task. At one falling clock edge that task raises the status input and also presents the clear write, then it reads the flag back after the next rising edge. A second hard case is a status input held high through reset. The bench reaches it by asserting reset again with that input already high.

// File: rtl/osc_irq_pkg.sv
package osc_irq_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int NUM_FLAGS = 3;

    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_FLAG   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FSET   = 8'h10;

    typedef enum logic [2:0] {
        SEL_EN_CLR,
        SEL_EN_SET,
        SEL_FLAG,
        SEL_STAT,
        SEL_FSET,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_EN_CLR: return SEL_EN_CLR;
            OFS_EN_SET: return SEL_EN_SET;
            OFS_FLAG:   return SEL_FLAG;
            OFS_STAT:   return SEL_STAT;
            OFS_FSET:   return SEL_FSET;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/osc_irq_edge.sv
module osc_irq_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level_in,
    output logic [W-1:0] rise
);
    logic [W-1:0] level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= level_in;
    end

    assign rise = level_in & ~level_q;

    // R2: a rise is reported only when the input was low one edge earlier
    a_r2_rise_after_low: assert property (@(posedge clk) disable iff (rst)
        1 |=> ((rise & $past(level_in)) == '0));
endmodule

// File: rtl/osc_irq_flags.sv
module osc_irq_flags #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] sw_set,
    input  logic [W-1:0] sw_clr,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_d;

    // set has priority over clear (R8)
    assign flags_d = (flags & ~sw_clr) | hw_set | sw_set;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_d;
    end

    a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
        1 |=> ((flags & $past(hw_set)) == $past(hw_set)));

    a_r4_soft_set: assert property (@(posedge clk) disable iff (rst)
        1 |=> ((flags & $past(sw_set)) == $past(sw_set)));

    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        1 |=> ((flags & $past(sw_clr & ~hw_set & ~sw_set)) == '0));

    // R8: a set event overrides a clear in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        ((sw_clr & hw_set) != '0) |=> ((flags & $past(sw_clr & hw_set)) != '0));
endmodule

// File: rtl/osc_irq_enable.sv
module osc_irq_enable #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] en
);
    always_ff @(posedge clk) begin
        if (rst) en <= '0;
        else     en <= (en & ~clr_mask) | set_mask;
    end

    a_r6_en_rise_needs_set: assert property (@(posedge clk) disable iff (rst)
        1 |=> ((en & ~$past(en) & ~$past(set_mask)) == '0));

    a_r6_en_fall_needs_clr: assert property (@(posedge clk) disable iff (rst)
        1 |=> ((~en & $past(en) & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/osc_irq_ctrl.sv
module osc_irq_ctrl
    import osc_irq_pkg::*;
#(
    parameter int NF = NUM_FLAGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wr_lock,
    input  logic [NF-1:0]     status_in,
    output logic              irq
);
    localparam int PAD_W = DATA_W - NF;

    reg_sel_e       sel;
    logic [NF-1:0]  wmask;
    logic [NF-1:0]  hw_set, sw_set, sw_clr, en_set, en_clr;
    logic [NF-1:0]  flags, en;
    logic           open_wr;
    logic           unused_wdata_hi;

    assign sel             = decode_addr(bus_addr);
    assign wmask           = bus_wdata[NF-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NF];
    assign open_wr         = bus_we && !wr_lock;

    assign sw_clr = (bus_we  && sel == SEL_FLAG)   ? wmask : '0;
    assign sw_set = (open_wr && sel == SEL_FSET)   ? wmask : '0;
    assign en_set = (open_wr && sel == SEL_EN_SET) ? wmask : '0;
    assign en_clr = (open_wr && sel == SEL_EN_CLR) ? wmask : '0;

    osc_irq_edge #(.W(NF)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_in (status_in),
        .rise     (hw_set)
    );

    osc_irq_flags #(.W(NF)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .hw_set (hw_set),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .flags  (flags)
    );

    osc_irq_enable #(.W(NF)) u_en (
        .clk      (clk),
        .rst      (rst),
        .set_mask (en_set),
        .clr_mask (en_clr),
        .en       (en)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(flags & en);
    end

    always_comb begin
        case (sel)
            SEL_EN_CLR, SEL_EN_SET: bus_rdata = {{PAD_W{1'b0}}, en};
            SEL_FLAG, SEL_FSET:     bus_rdata = {{PAD_W{1'b0}}, flags};
            SEL_STAT:               bus_rdata = {{PAD_W{1'b0}}, status_in};
            default:                bus_rdata = '0;
        endcase
    end

    a_r7_irq_registered: assert property (@(posedge clk) disable iff (rst)
        1 |=> (irq == $past(|(flags & en))));

    a_r5_lock_enables: assert property (@(posedge clk) disable iff (rst)
        (bus_we && wr_lock && (sel == SEL_EN_SET || sel == SEL_EN_CLR)) |=> $stable(en));

    a_r5_lock_fset: assert property (@(posedge clk) disable iff (rst)
        (bus_we && wr_lock && sel == SEL_FSET) |=>
            ((flags & ~$past(flags | hw_set)) == '0));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        1 |-> (bus_rdata[DATA_W-1:NF] == '0));
endmodule

// File: tb/osc_irq_ctrl_tb.sv
`timescale 1ns/1ps
module osc_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wr_lock = 1'b0;
    logic [2:0]  status_in = '0;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    osc_irq_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wr_lock   (wr_lock),
        .status_in (status_in),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        rd_check("R1 flags", 8'h08, 0);
        rd_check("R1 enables", 8'h04, 0);
        rd_check("R1 set alias", 8'h10, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_edges;
        @(negedge clk) status_in = 3'b001;
        @(posedge clk);
        rd_check("R2 rise bit0", 8'h08, 32'h1);
        wr(8'h08, 32'h1);
        repeat (3) @(posedge clk);
        rd_check("R2 level no reset", 8'h08, 32'h0);
        @(negedge clk) status_in = 3'b100;
        @(posedge clk);
        rd_check("R2 rise bit2", 8'h08, 32'h4);
    endtask

    task automatic t_clear;
        wr(8'h08, 32'h0);
        rd_check("R3 zero write", 8'h08, 32'h4);
        wr(8'h08, 32'h4);
        rd_check("R3 clear", 8'h08, 32'h0);
    endtask

    task automatic t_soft_set;
        wr(8'h10, 32'h3);
        rd_check("R4 alias read", 8'h10, 32'h3);
        rd_check("R4 flag read", 8'h08, 32'h3);
        wr(8'h10, 32'h0);
        rd_check("R4 zero write", 8'h10, 32'h3);
        wr(8'h08, 32'h7);
    endtask

    task automatic t_lock;
        wr_lock = 1'b1;
        wr(8'h10, 32'h7);
        rd_check("R5 set alias locked", 8'h08, 32'h0);
        wr(8'h04, 32'h7);
        rd_check("R5 enable set locked", 8'h04, 32'h0);
        wr_lock = 1'b0;
        wr(8'h04, 32'h2);
        wr(8'h10, 32'h2);
        wr_lock = 1'b1;
        wr(8'h00, 32'h2);
        rd_check("R5 enable clear locked", 8'h00, 32'h2);
        wr(8'h08, 32'h2);
        rd_check("R5 flag clear unlocked", 8'h08, 32'h0);
        wr_lock = 1'b0;
        wr(8'h00, 32'h7);
    endtask

    task automatic t_enable;
        wr(8'h04, 32'h5);
        rd_check("R6 read clr alias", 8'h00, 32'h5);
        rd_check("R6 read set alias", 8'h04, 32'h5);
        wr(8'h00, 32'h1);
        rd_check("R6 after clear", 8'h04, 32'h4);
    endtask

    task automatic t_irq;
        wr(8'h10, 32'h1);
        @(negedge clk);
        check("R7 masked flag", {31'd0, irq}, 0);
        @(negedge clk);
        bus_addr = 8'h10; bus_wdata = 32'h4; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        check("R7 not yet", {31'd0, irq}, 0);
        @(negedge clk);
        check("R7 asserted", {31'd0, irq}, 1);
        bus_addr = 8'h00; bus_wdata = 32'h4; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        check("R7 still high", {31'd0, irq}, 1);
        @(negedge clk);
        check("R7 dropped", {31'd0, irq}, 0);
        wr(8'h08, 32'h7);
    endtask

    task automatic t_collide;
        status_in = 3'b000;
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 32'h2; bus_we = 1'b1;
        status_in = 3'b010;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        rd_check("R8 set wins", 8'h08, 32'h2);
        wr(8'h08, 32'h7);
    endtask

    task automatic t_reserved;
        wr(8'h10, 32'hFFFF_FFF8);
        rd_check("R10 reserved write", 8'h10, 32'h0);
        status_in = 3'b101;
        rd_check("R10 live status", 8'h0C, 32'h5);
        rd_check("R10 unmapped", 8'h14, 32'h0);
        wr(8'h08, 32'h7);
    endtask

    task automatic t_reset_high;
        @(negedge clk);
        status_in = 3'b010;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rd_check("R1 flags during reset", 8'h08, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        rd_check("R9 flag after reset", 8'h08, 32'h2);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_edges();
        t_clear();
        t_soft_set();
        t_lock();
        t_enable();
        t_irq();
        t_collide();
        t_reserved();
        t_reset_high();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule